// File: doc/BRIEF.md
# Two-Wire Target with a 16-Bit Register File

This block is the target side of a two-wire serial control bus that an image sensor uses for its settings. It holds 256 registers of 16 bits each. An 8-bit register pointer selects the register. A controller reaches the block at the fixed 7-bit device address 0x5C. A write transaction first loads the pointer, then streams 16-bit words, high byte first. A read transaction follows a pointer write and a repeated START, and streams words back from the pointer. The pointer moves once per complete 16-bit word, never per byte.

SCL and SDA enter through synchronizers clocked by the system clock. All bus events (SCL edges, START, STOP) are decoded from the synchronized levels. The block drives SDA in open-drain style through an enable and a value; a '0' with the enable set pulls the line low. The controller drives SCL, and the block never stretches it.

The state machine has these states: `ST_IDLE`, `ST_DEV` (address byte in), `ST_DEVACK`, `ST_PTR` (pointer byte in), `ST_PTRACK`, `ST_WDAT` (data byte in), `ST_WACK`, `ST_RDAT` (data byte out), `ST_RACK` (controller acknowledge), and `ST_SKIP` (bus ignored). The transitions are as follows:
- A START moves any state to `ST_DEV`.
- A STOP moves any state to `ST_IDLE`.
- All other moves happen on a falling SCL edge:
  - `ST_DEV` goes to `ST_DEVACK` on an address match, or to `ST_SKIP` otherwise.
  - `ST_DEVACK` goes to `ST_RDAT` for a read, or to `ST_PTR` for a write.
  - `ST_PTR` goes to `ST_PTRACK`, then to `ST_WDAT`.
  - `ST_WDAT` and `ST_WACK` alternate.
  - `ST_RDAT` goes to `ST_RACK`.
  - `ST_RACK` returns to `ST_RDAT` on an acknowledge, or goes to `ST_SKIP` on a not-acknowledge.

Top module: `tw_reg16_target`

## Requirements
- R1: After reset the SDA enable is low, and register N holds the value {N xor 0xA5, N} (high byte, low byte).
- R2: The address byte 0xB8 (write) or 0xB9 (read), which is 7-bit address 0x5C plus a direction bit in bit 0, is acknowledged: SDA is held low during the ninth SCL pulse.
- R3: An address byte with another 7-bit address is not acknowledged. Every later byte up to the next START is also not acknowledged and changes no register.
- R4: In a write, the byte after the address loads the register pointer. Each later byte is a data byte taken MSB first. The pointer byte and every data byte are acknowledged.
- R5: A register is written only when both bytes of its word (high byte, then low byte) have arrived. A lone high byte followed by STOP or by START leaves the register unchanged.
- R6: The pointer advances by one after each complete 16-bit word, whether written or read. It wraps from 0xFF to 0x00.
- R7: After a pointer write, a repeated START and 0xB9, the block shifts out the high byte and then the low byte of the addressed register, MSB first. Consecutive words come from consecutive registers.
- R8: During a read, a controller acknowledge (SDA low in the ninth pulse) continues the transfer. A not-acknowledge ends it, and SDA stays released until the next START.
- R9: A START (SDA falling while SCL is high) restarts address reception from any state. A STOP (SDA rising while SCL is high) returns the block to idle. The block turns on its SDA drive only while SCL is low.
- R10: The pointer keeps its value across STOP, so a later read without a new pointer byte can follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | SDA drive enable |
| sda_o | output | 1 | SDA value while enabled (0 pulls low) |

## Verification
The assertions take three things for granted about the bus:
- SCL stays low for more than one system clock after each falling edge.
- The controller changes SDA only while SCL is low, except for START and STOP.
- The controller never starts a new transaction while the block is pulling SDA low.

The bench keeps within these limits. Its controller tasks hold each SCL phase for several system clocks, and they change SDA only in the middle of the low phase. They end every read with a not-acknowledge before any START or STOP.

// File: rtl/tw16_pkg.sv
package tw16_pkg;

    localparam int TW_PTR_W  = 8;
    localparam int TW_BYTE_W = 8;
    localparam int TW_WORD_W = 2 * TW_BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEVACK,
        ST_PTR,
        ST_PTRACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } tw_state_e;

    // Reset content of one register: {index xor 0xA5, index}
    function automatic logic [TW_WORD_W-1:0] reset_word(input logic [TW_PTR_W-1:0] idx);
        return {idx ^ 8'hA5, idx};
    endfunction

endpackage

// File: rtl/tw16_sync.sv
module tw16_sync #(
    parameter int STAGES = 2   // must be at least 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_lvl   = scl_ff[STAGES-1];
    assign sda_lvl   = sda_ff[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/tw16_regfile.sv
module tw16_regfile
    import tw16_pkg::*;
#(
    parameter int PTR_W  = TW_PTR_W,
    parameter int WORD_W = TW_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << PTR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= reset_word(PTR_W'(i));
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R5: a committed word is present in the addressed register afterwards
    p_commit_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/tw_reg16_target.sv
module tw_reg16_target
    import tw16_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h5C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic sda_o
);

    localparam int CNT_W = $clog2(TW_BYTE_W + 1);

    tw_state_e              st_q, st_d;
    logic [CNT_W-1:0]       bit_cnt;
    logic [TW_BYTE_W-1:0]   rx_sr;
    logic [TW_BYTE_W-1:0]   tx_sr;
    logic [TW_BYTE_W-1:0]   hi_hold;
    logic [TW_PTR_W-1:0]    ptr_q;
    logic                   hi_valid;
    logic                   byte_sel;
    logic                   rw_q;
    logic                   m_nack;
    logic                   byte_full;
    logic                   reg_we;
    logic [TW_WORD_W-1:0]   rd_word;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    tw16_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_full = (bit_cnt == CNT_W'(TW_BYTE_W));
    assign reg_we    = (st_q == ST_WDAT) && scl_fall && byte_full && hi_valid;

    tw16_regfile #(.PTR_W(TW_PTR_W), .WORD_W(TW_WORD_W)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (ptr_q),
        .wdata ({hi_hold, rx_sr}),
        .raddr (ptr_q),
        .rdata (rd_word)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (start_det) begin
            st_d = ST_DEV;
        end else if (stop_det) begin
            st_d = ST_IDLE;
        end else if (scl_fall) begin
            unique case (st_q)
                ST_DEV:    if (byte_full) st_d = (rx_sr[7:1] == DEV_ADDR) ? ST_DEVACK : ST_SKIP;
                ST_DEVACK: st_d = rw_q ? ST_RDAT : ST_PTR;
                ST_PTR:    if (byte_full) st_d = ST_PTRACK;
                ST_PTRACK: st_d = ST_WDAT;
                ST_WDAT:   if (byte_full) st_d = ST_WACK;
                ST_WACK:   st_d = ST_WDAT;
                ST_RDAT:   if (byte_full) st_d = ST_RACK;
                ST_RACK:   st_d = m_nack ? ST_SKIP : ST_RDAT;
                default:   st_d = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // byte, pointer and word assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '1;
            hi_hold  <= '0;
            ptr_q    <= '0;
            hi_valid <= 1'b0;
            byte_sel <= 1'b0;
            rw_q     <= 1'b0;
            m_nack   <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt  <= '0;
            hi_valid <= 1'b0;
            byte_sel <= 1'b0;
            m_nack   <= 1'b0;
        end else if (scl_rise) begin
            unique case (st_q)
                ST_DEV, ST_PTR, ST_WDAT, ST_RDAT: begin
                    if (!byte_full) begin
                        rx_sr   <= {rx_sr[TW_BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                ST_RACK: m_nack <= sda_lvl;
                default: ;
            endcase
        end else if (scl_fall) begin
            unique case (st_q)
                ST_DEV: if (byte_full) rw_q <= rx_sr[0];
                ST_DEVACK: begin
                    bit_cnt  <= '0;
                    byte_sel <= 1'b0;
                    tx_sr    <= rd_word[TW_WORD_W-1:TW_BYTE_W];
                end
                ST_PTR: if (byte_full) ptr_q <= rx_sr;
                ST_PTRACK: begin
                    bit_cnt  <= '0;
                    hi_valid <= 1'b0;
                end
                ST_WDAT: begin
                    if (byte_full) begin
                        if (hi_valid) begin
                            hi_valid <= 1'b0;
                            ptr_q    <= ptr_q + TW_PTR_W'(1);
                        end else begin
                            hi_hold  <= rx_sr;
                            hi_valid <= 1'b1;
                        end
                    end
                end
                ST_WACK: bit_cnt <= '0;
                ST_RDAT: begin
                    if (byte_full) begin
                        byte_sel <= ~byte_sel;
                        if (byte_sel) ptr_q <= ptr_q + TW_PTR_W'(1);
                    end else begin
                        tx_sr <= {tx_sr[TW_BYTE_W-2:0], 1'b1};
                    end
                end
                ST_RACK: begin
                    bit_cnt <= '0;
                    tx_sr   <= byte_sel ? rd_word[TW_BYTE_W-1:0]
                                        : rd_word[TW_WORD_W-1:TW_BYTE_W];
                end
                default: ;
            endcase
        end
    end

    // SDA drive
    always_comb begin
        sda_oe_o = 1'b0;
        sda_o    = 1'b1;
        unique case (st_q)
            ST_DEVACK, ST_PTRACK, ST_WACK: begin
                sda_oe_o = 1'b1;
                sda_o    = 1'b0;
            end
            ST_RDAT: begin
                sda_oe_o = 1'b1;
                sda_o    = tx_sr[TW_BYTE_W-1];
            end
            default: ;
        endcase
    end

    // R9: a START always rearms address reception
    p_start_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> st_q == ST_DEV);

    // R9: a STOP always returns to idle
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> st_q == ST_IDLE);

    // R9: drive is switched on only while the synchronized SCL is low
    p_oe_low_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl);

    // R5: after a commit no high byte remains pending
    p_commit_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !hi_valid);

    // R6: the pointer steps by one per committed word
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> ptr_q == $past(ptr_q) + TW_PTR_W'(1));

endmodule

// File: tb/tw_reg16_target_tb_top.sv
module tw_reg16_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 6;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic oe, sdo;
    logic sda_bus;

    assign sda_bus = (oe && !sdo) ? 1'b0 : sda_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_reg16_target dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (oe),
        .sda_o    (sdo)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] model [256];
    logic [15:0] wbuf  [8];

    function automatic logic [15:0] rst_val(input int i);
        return {8'(i) ^ 8'hA5, 8'(i)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic s);
        wait_q(); sda_m = b;
        wait_q(); scl_m = 1'b1;
        wait_q(); s = sda_bus;
        wait_q(); scl_m = 1'b0;
    endtask

    task automatic m_start();
        wait_q(); sda_m = 1'b1;
        wait_q(); scl_m = 1'b1;
        wait_q(); sda_m = 1'b0;
        wait_q(); scl_m = 1'b0;
    endtask

    task automatic m_stop();
        wait_q(); sda_m = 1'b0;
        wait_q(); scl_m = 1'b1;
        wait_q(); sda_m = 1'b1;
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            b[i] = s;
        end
        bit_io(!ack, s);
    endtask

    task automatic do_write(input logic [7:0] p, input int n);
        logic a;
        m_start();
        send_byte(8'hB8, a); chk("R2", a, 1, "write address ack");
        send_byte(p, a);     chk("R4", a, 1, "pointer ack");
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k][15:8], a); chk("R4", a, 1, "high byte ack");
            send_byte(wbuf[k][7:0], a);  chk("R4", a, 1, "low byte ack");
            model[8'(p + k)] = wbuf[k];
        end
        m_stop();
    endtask

    task automatic do_read(input logic [7:0] p, input int n, input string tag);
        logic a;
        logic [7:0] hb, lb;
        m_start();
        send_byte(8'hB8, a); chk("R2", a, 1, "address ack before read");
        send_byte(p, a);     chk("R4", a, 1, "pointer ack before read");
        m_start();
        send_byte(8'hB9, a); chk("R2", a, 1, "read address ack");
        for (int k = 0; k < n; k++) begin
            recv_byte(1'b1, hb);
            recv_byte(k != n - 1, lb);
            chk(tag, {hb, lb}, model[8'(p + k)], $sformatf("R7 read word at %h", 8'(p + k)));
        end
        m_stop();
    endtask

    initial begin
        logic a;
        logic s;
        logic [7:0] hb, lb;
        logic [7:0] ones;
        for (int i = 0; i < 256; i++) model[i] = rst_val(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1", oe, 0, "SDA enable after reset");
        chk("R1", sda_bus, 1, "bus level after reset");
        do_read(8'h05, 2, "R1");

        // worked example: 0x0284 to register 0x09
        wbuf[0] = 16'h0284;
        do_write(8'h09, 1);
        do_read(8'h09, 1, "R4");

        // R10: pointer survives STOP; read without new pointer byte
        wbuf[0] = 16'h1111; wbuf[1] = 16'h2222;
        do_write(8'h40, 2);
        m_start();
        send_byte(8'hB9, a); chk("R10", a, 1, "read address ack");
        recv_byte(1'b1, hb); recv_byte(1'b0, lb);
        chk("R10", {hb, lb}, model[8'h42], "word at retained pointer");
        // R8: after NACK the line stays released
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            ones[i] = s;
        end
        bit_io(1'b1, s);
        chk("R8", {ones, s}, 9'h1FF, "bus released after NACK");
        m_stop();

        // R3: wrong address, then bytes that must be ignored
        m_start();
        send_byte(8'hA0, a); chk("R3", a, 0, "wrong address not acked");
        send_byte(8'h09, a); chk("R3", a, 0, "byte after wrong address");
        send_byte(8'h55, a); chk("R3", a, 0, "data after wrong address");
        send_byte(8'h66, a); chk("R3", a, 0, "data after wrong address");
        m_stop();
        m_start();
        send_byte(8'hBA, a); chk("R3", a, 0, "neighbour address not acked");
        m_stop();
        do_read(8'h09, 1, "R3");

        // R5: lone high byte then STOP
        m_start();
        send_byte(8'hB8, a); send_byte(8'h20, a);
        send_byte(8'h77, a); chk("R5", a, 1, "lone high byte ack");
        m_stop();
        do_read(8'h20, 1, "R5");

        // R5/R9: lone high byte then repeated START, new write elsewhere
        m_start();
        send_byte(8'hB8, a); send_byte(8'h21, a);
        send_byte(8'h55, a);
        m_start();
        send_byte(8'hB8, a); chk("R9", a, 1, "address after repeated START");
        send_byte(8'h30, a);
        send_byte(8'h12, a); send_byte(8'h34, a);
        m_stop();
        model[8'h30] = 16'h1234;
        do_read(8'h21, 1, "R5");
        do_read(8'h30, 1, "R9");

        // R6: pointer wrap on write and read
        wbuf[0] = 16'hBEEF; wbuf[1] = 16'hCAFE;
        do_write(8'hFF, 2);
        do_read(8'hFF, 2, "R6");
        chk("R6", model[8'h01], rst_val(1), "register past the wrap untouched in model");
        do_read(8'h01, 1, "R6");

        // random bursts with a fixed seed
        void'($urandom(32'd1357));
        for (int t = 0; t < 12; t++) begin
            logic [7:0] p;
            int n;
            p = 8'($urandom);
            n = 1 + int'($urandom % 3);
            for (int k = 0; k < n; k++) wbuf[k] = 16'($urandom);
            do_write(p, n);
            do_read(p, n, "R7");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule